// File: doc/BRIEF.md
# Queued SPI master controller

This block is an SPI master that works through a list of up to sixteen transfers without processor help. Software loads the words to send into a transmit RAM and one control byte per list entry into a command RAM. It then programs a first-entry pointer and a last-entry pointer and sets the run bit. For each entry the controller drives the four peripheral chip-select lines from the low nibble of that entry's command byte. It shifts out the 16-bit word and stores the word shifted in from the peripheral into a receive RAM at the same index.

When the last entry has been sent, a completion flag is raised, and it can also raise an interrupt. With wrap enabled, the controller returns to the first entry and keeps going until software clears the run bit. With wrap disabled, it stops after one pass. All storage and registers sit behind a simple word-wide bus. Read data is valid on the cycle after the read strobe.

Top module: `spi_queue_master`

## Requirements
- R1: After synchronous reset, spi_cs is all ones, spi_sck, spi_mosi and irq are 0, and the control word (address 0x00), configuration word (0x01) and status word (0x02) all read as 0. Bus read data appears on the cycle after bus_re.
- R2: Each transfer is 16 bits, most significant bit first, in SPI mode 0 (clock idles low, data changes only while the clock is low, input sampled on the rising edge). The serial clock period is 4 system clocks.
- R3: Writing 1 to bit 15 of the control word (0x00) while the controller is idle starts a pass at the first-entry pointer (configuration bits [3:0]). Entries run in ascending index order, and the index steps from 15 to 0, so a first pointer above the last pointer (bits [7:4]) is legal.
- R4: With wrap off (configuration bit 8 = 0), exactly ((last - first) mod 16) + 1 transfers run. After them, control bit 15 reads 0 and spi_cs returns to all ones.
- R5: With wrap on, after the last entry the controller continues from the first entry without stopping, and the completion flag is set at the end of each pass.
- R6: During an entry's transfer, spi_cs equals bits [3:0] of the command byte at address 0x20+index, and the upper command bits have no effect. A byte of 0 drives all four lines low.
- R7: The word shifted out for an entry is the transmit RAM word at address 0x10+index.
- R8: The word received during an entry's transfer is stored at that index in the receive RAM and reads back at address 0x30+index.
- R9: The completion flag (status bit 0) is set when the last entry's transfer completes. irq is 1 exactly while the flag and the interrupt enable (configuration bit 9) are both 1.
- R10: The flag clears only on a write of 0 to bit 0 of the status word that follows a read of the status word made while the flag was 1. Any status write ends that permission, so a write without such a prior read leaves the flag set.
- R11: Clearing control bit 15 during a run lets the current transfer finish, then stops with spi_cs all ones. The entry index in status bits [7:4] keeps the index of that last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | 6 | Word address: bits [5:4] region (registers, transmit, command, receive), bits [3:0] index |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, valid the cycle after bus_re |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Peripheral chip-select levels |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the stop request that arrives in the middle of a wrapped run. The bench must show that the transfer in flight completes and that the index is held, which only happens if the clear lands between serial clock edges of a transfer that is already partly shifted. The bench counts completed transfers through its own peripheral model. After the seventh completed transfer it waits twenty clocks and clears the run bit, which places the request well inside the eighth transfer. The flag handshake is also awkward to reach, because any status read arms the clear. The bench therefore disarms with a write of 1, and only then shows that a bare write of 0 leaves the flag set.

// File: rtl/spi_qm_pkg.sv
package spi_qm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_LOAD  = 2'd2,
    SQ_XFER  = 2'd3
  } sq_state_t;

  localparam logic [1:0] RG_REGS = 2'd0;
  localparam logic [1:0] RG_TX   = 2'd1;
  localparam logic [1:0] RG_CMD  = 2'd2;
  localparam logic [1:0] RG_RX   = 2'd3;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CFG  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

endpackage

// File: rtl/spi_qm_ram.sv
module spi_qm_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_qm_shifter.sv
module spi_qm_shifter #(
  parameter int DATA_W  = 16,
  parameter int SCK_DIV = 4,
  localparam int HALF   = SCK_DIV / 2,
  localparam int DIV_W  = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  logic              active;
  logic [DIV_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        div_cnt <= '0;
        bit_cnt <= '0;
        tx_sh   <= tx_word;
        mosi    <= tx_word[DATA_W-1];
        sck     <= 1'b0;
      end else if (active) begin
        if (div_cnt == DIV_W'(SCK_DIV - 1)) begin
          div_cnt <= '0;
          sck     <= 1'b0;
          if (bit_cnt == BIT_W'(DATA_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
            mosi    <= tx_sh[DATA_W-2];
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
          if (div_cnt == DIV_W'(HALF - 1)) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
          end
        end
      end
    end
  end

  assign rx_word = rx_sh;

endmodule

// File: rtl/spi_qm_regs.sv
module spi_qm_regs
  import spi_qm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              done_set,
  input  logic              run_clr,
  input  logic [PTR_W-1:0]  cur_ptr,
  output logic              run_en,
  output logic [PTR_W-1:0]  first_ptr,
  output logic [PTR_W-1:0]  last_ptr,
  output logic              wrap_en,
  output logic              irq_en,
  output logic              done_flag,
  output logic              irq
);

  localparam int WRAP_BIT = 2 * PTR_W;
  localparam int IE_BIT   = 2 * PTR_W + 1;

  logic ctrl_wr, cfg_wr, stat_wr, stat_rd;
  logic clr_armed;
  logic flag_d, ie_d;
  logic unused_bits;

  assign ctrl_wr = wr_en && (reg_sel == REG_CTRL);
  assign cfg_wr  = wr_en && (reg_sel == REG_CFG);
  assign stat_wr = wr_en && (reg_sel == REG_STAT);
  assign stat_rd = rd_en && (reg_sel == REG_STAT);
  assign unused_bits = ^wdata;

  always_comb begin
    flag_d = done_flag;
    if (done_set) begin
      flag_d = 1'b1;
    end else if (stat_wr && clr_armed && !wdata[0]) begin
      flag_d = 1'b0;
    end
    ie_d = cfg_wr ? wdata[IE_BIT] : irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      first_ptr <= '0;
      last_ptr  <= '0;
      wrap_en   <= 1'b0;
      irq_en    <= 1'b0;
      done_flag <= 1'b0;
      clr_armed <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_en <= wdata[DATA_W-1];
      end else if (run_clr) begin
        run_en <= 1'b0;
      end
      if (cfg_wr) begin
        first_ptr <= wdata[PTR_W-1:0];
        last_ptr  <= wdata[2*PTR_W-1:PTR_W];
        wrap_en   <= wdata[WRAP_BIT];
      end
      irq_en    <= ie_d;
      done_flag <= flag_d;
      irq       <= flag_d & ie_d;
      if (stat_wr) begin
        clr_armed <= 1'b0;
      end else if (stat_rd && done_flag) begin
        clr_armed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (rd_en) begin
        unique case (reg_sel)
          REG_CTRL: rdata[DATA_W-1] <= run_en;
          REG_CFG: begin
            rdata[PTR_W-1:0]       <= first_ptr;
            rdata[2*PTR_W-1:PTR_W] <= last_ptr;
            rdata[WRAP_BIT]        <= wrap_en;
            rdata[IE_BIT]          <= irq_en;
          end
          REG_STAT: begin
            rdata[0]           <= done_flag;
            rdata[PTR_W+3:4]   <= cur_ptr;
          end
          default: rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_qm_seq.sv
module spi_qm_seq
  import spi_qm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CMD_W = 8,
  parameter int NCS   = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [PTR_W-1:0] first_ptr,
  input  logic [PTR_W-1:0] last_ptr,
  input  logic             wrap_en,
  input  logic [CMD_W-1:0] cmd_rdata,
  input  logic             xfer_done,
  output logic             xfer_start,
  output logic [PTR_W-1:0] ptr,
  output logic [NCS-1:0]   cs_out,
  output logic             rx_we,
  output logic             done_set,
  output logic             run_clr,
  output sq_state_t        state
);

  logic at_end;
  logic unused_cmd;
  logic [PTR_W-1:0] ptr_next;

  assign at_end     = (ptr == last_ptr);
  assign ptr_next   = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign xfer_start = (state == SQ_LOAD);
  assign rx_we      = xfer_done;
  assign done_set   = xfer_done && at_end;
  assign run_clr    = xfer_done && at_end && !wrap_en;
  assign unused_cmd = ^cmd_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      ptr    <= '0;
      cs_out <= '1;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          cs_out <= '1;
          if (run_en) begin
            ptr   <= first_ptr;
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: state <= SQ_LOAD;
        SQ_LOAD: begin
          cs_out <= cmd_rdata[NCS-1:0];
          state  <= SQ_XFER;
        end
        SQ_XFER: begin
          if (xfer_done) begin
            if (!run_en || (at_end && !wrap_en)) begin
              state  <= SQ_IDLE;
              cs_out <= '1;
            end else if (at_end) begin
              ptr   <= first_ptr;
              state <= SQ_FETCH;
            end else begin
              ptr   <= ptr_next;
              state <= SQ_FETCH;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spi_qm_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 16,
  parameter int CMD_W   = 8,
  parameter int NCS     = 4,
  parameter int SCK_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [$clog2(DEPTH)+1:0]   bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       spi_sck,
  output logic                       spi_mosi,
  input  logic                       spi_miso,
  output logic [NCS-1:0]             spi_cs,
  output logic                       irq
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int ADDR_W = PTR_W + 2;

  logic [1:0]        region;
  logic [PTR_W-1:0]  index;
  logic              rx_sel_q;

  logic              run_en, wrap_en, irq_en, done_flag;
  logic [PTR_W-1:0]  first_ptr, last_ptr, cur_ptr;
  logic [DATA_W-1:0] reg_rdata, rx_rdata, tx_rdata, rx_word;
  logic [CMD_W-1:0]  cmd_rdata;
  logic              xfer_start, xfer_done, rx_we, done_set, run_clr;
  sq_state_t         seq_state;

  assign region = bus_addr[ADDR_W-1 -: 2];
  assign index  = bus_addr[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sel_q <= 1'b0;
    end else begin
      rx_sel_q <= bus_re && (region == RG_RX);
    end
  end

  assign bus_rdata = rx_sel_q ? rx_rdata : reg_rdata;

  spi_qm_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_we && (region == RG_REGS)),
    .rd_en     (bus_re && (region == RG_REGS)),
    .reg_sel   (bus_addr[1:0]),
    .wdata     (bus_wdata),
    .rdata     (reg_rdata),
    .done_set  (done_set),
    .run_clr   (run_clr),
    .cur_ptr   (cur_ptr),
    .run_en    (run_en),
    .first_ptr (first_ptr),
    .last_ptr  (last_ptr),
    .wrap_en   (wrap_en),
    .irq_en    (irq_en),
    .done_flag (done_flag),
    .irq       (irq)
  );

  spi_qm_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_ram (
    .clk   (clk),
    .we    (bus_we && (region == RG_TX)),
    .waddr (index),
    .wdata (bus_wdata),
    .raddr (cur_ptr),
    .rdata (tx_rdata)
  );

  spi_qm_ram #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_cmd_ram (
    .clk   (clk),
    .we    (bus_we && (region == RG_CMD)),
    .waddr (index),
    .wdata (bus_wdata[CMD_W-1:0]),
    .raddr (cur_ptr),
    .rdata (cmd_rdata)
  );

  spi_qm_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_ram (
    .clk   (clk),
    .we    (rx_we),
    .waddr (cur_ptr),
    .wdata (rx_word),
    .raddr (index),
    .rdata (rx_rdata)
  );

  spi_qm_seq #(.DEPTH(DEPTH), .CMD_W(CMD_W), .NCS(NCS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .first_ptr  (first_ptr),
    .last_ptr   (last_ptr),
    .wrap_en    (wrap_en),
    .cmd_rdata  (cmd_rdata),
    .xfer_done  (xfer_done),
    .xfer_start (xfer_start),
    .ptr        (cur_ptr),
    .cs_out     (spi_cs),
    .rx_we      (rx_we),
    .done_set   (done_set),
    .run_clr    (run_clr),
    .state      (seq_state)
  );

  spi_qm_shifter #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (xfer_start),
    .tx_word (tx_rdata),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (xfer_done),
    .rx_word (rx_word)
  );

endmodule

// File: rtl/spi_qm_checker.sv
module spi_qm_checker
  import spi_qm_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter int NCS   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_sck,
  input logic             spi_mosi,
  input logic [NCS-1:0]   spi_cs,
  input sq_state_t        state,
  input logic [PTR_W-1:0] ptr,
  input logic [PTR_W-1:0] last_ptr,
  input logic             done_flag,
  input logic             rx_we
);

  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) |-> (spi_cs == '1)); // R6

  AST_SCK_ONLY_XFER: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> (state == SQ_XFER)); // R2

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R2

  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(rx_we && (ptr == last_ptr))); // R9

  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((state == SQ_IDLE) && ($past(state) == SQ_IDLE)) |-> $stable(ptr)); // R11

endmodule

bind spi_queue_master spi_qm_checker #(.PTR_W(PTR_W), .NCS(NCS)) i_checker (
  .clk       (clk),
  .rst       (rst),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .spi_cs    (spi_cs),
  .state     (seq_state),
  .ptr       (cur_ptr),
  .last_ptr  (last_ptr),
  .done_flag (done_flag),
  .rx_we     (rx_we)
);

// File: tb/test_spi_queue_master.sv
module test_spi_queue_master;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we, bus_re;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso, irq;
  logic [3:0]  spi_cs;

  always #4 clk = ~clk;

  spi_queue_master i_spi_queue_master (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // peripheral model: logs each 16-bit word and the select levels
  int          xfer_k = 0;
  int          bitc = 0;
  logic [15:0] cap = '0;
  logic [15:0] cap_log [0:1023];
  logic [3:0]  cs_log  [0:1023];
  logic [15:0] cur_reply;

  function automatic logic [15:0] reply(int k);
    return 16'h3C5A ^ 16'(k * 4951);
  endfunction
  function automatic logic [15:0] txw(int i);
    return 16'(i * 16'h0F1D) ^ 16'hC3A5;
  endfunction
  function automatic logic [7:0] cmdv(int i);
    return 8'((i * 5 + 3) | (i << 4));
  endfunction

  always_comb cur_reply = reply(xfer_k);
  assign spi_miso = cur_reply[4'(15 - bitc)];

  always @(posedge spi_sck) begin
    cap = {cap[14:0], spi_mosi};
    if (bitc == 15) begin
      if (xfer_k < 1024) begin
        cap_log[xfer_k] = cap;
        cs_log[xfer_k]  = spi_cs;
      end
      xfer_k++;
      bitc = 0;
    end else begin
      bitc++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(string req);
    int c;
    c = 0;
    while (irq !== 1'b1 && c < 4000) begin
      @(negedge clk);
      c++;
    end
    chk(req, {31'd0, irq}, 32'd1);
  endtask

  // one pass without wrap, interrupt enabled; full check of the results
  task automatic run_pass(int s, int e);
    int k0, n, idx;
    logic [15:0] d;
    wr(6'h01, 16'(s | (e << 4) | (1 << 9)));
    k0 = xfer_k;
    wr(6'h00, 16'h8000);
    wait_irq("R9 irq on pass end");
    repeat (200) @(negedge clk);
    n = ((e - s) & 15) + 1;
    chk("R4 transfer count", 32'(xfer_k - k0), 32'(n));
    for (int j = 0; j < n; j++) begin
      idx = (s + j) & 15;
      chk("R7 R2 mosi word", {16'd0, cap_log[k0 + j]}, {16'd0, txw(idx)});
      chk("R6 cs level", {28'd0, cs_log[k0 + j]}, 32'((idx * 5 + 3) & 15));
      if (j == 0 || j == n - 1) begin
        rd(6'(6'h30 + idx), d);
        chk("R8 rx ram", {16'd0, d}, {16'd0, reply(k0 + j)});
      end
    end
    chk("R4 cs idle", {28'd0, spi_cs}, 32'hF);
    rd(6'h00, d);
    chk("R4 run bit cleared", {16'd0, d}, 32'd0);
    rd(6'h02, d);
    chk("R9 R11 status", {16'd0, d}, 32'((e << 4) | 1));
    wr(6'h02, 16'h0000);
    chk("R10 cleared irq", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int k0, t1, t2;
    rst = 1'b1; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs", {28'd0, spi_cs}, 32'hF);
    chk("R1 sck", {31'd0, spi_sck}, 32'd0);
    chk("R1 mosi", {31'd0, spi_mosi}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(6'h00, d); chk("R1 ctrl", {16'd0, d}, 32'd0);
    rd(6'h01, d); chk("R1 cfg", {16'd0, d}, 32'd0);
    rd(6'h02, d); chk("R1 status", {16'd0, d}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      wr(6'(6'h10 + i), txw(i));
      wr(6'(6'h20 + i), {8'd0, cmdv(i)});
    end

    // R3 whole queue, then a sweep of first/last pairs incl. index wrap
    run_pass(0, 15);
    for (int s = 0; s < 16; s++) begin
      run_pass(s, (s * 7 + 3) & 15);
    end
    run_pass(5, 5);

    // R9 flag without enable, R10 clear handshake
    wr(6'h01, 16'(1 | (2 << 4)));
    wr(6'h00, 16'h8000);
    repeat (400) @(negedge clk);
    chk("R9 irq gated by enable", {31'd0, irq}, 32'd0);
    rd(6'h02, d);
    chk("R9 flag set", {31'd0, d[0]}, 32'd1);
    wr(6'h02, 16'h0001);
    wr(6'h02, 16'h0000);
    rd(6'h02, d);
    chk("R10 bare write keeps flag", {31'd0, d[0]}, 32'd1);
    wr(6'h01, 16'(1 | (2 << 4) | (1 << 9)));
    @(negedge clk);
    chk("R9 irq follows enable", {31'd0, irq}, 32'd1);
    wr(6'h02, 16'h0000);
    rd(6'h02, d);
    chk("R10 read then write clears", {31'd0, d[0]}, 32'd0);
    chk("R10 irq low", {31'd0, irq}, 32'd0);

    // R5 wrap run, R11 stop in mid transfer
    wr(6'h01, 16'(2 | (4 << 4) | (1 << 8) | (1 << 9)));
    k0 = xfer_k;
    wr(6'h00, 16'h8000);
    @(posedge spi_sck); t1 = cyc;
    @(posedge spi_sck); t2 = cyc;
    chk("R2 sck period", 32'(t2 - t1), 32'd4);
    for (int c = 0; c < 8000 && xfer_k < k0 + 7; c++) @(negedge clk);
    repeat (20) @(negedge clk);
    wr(6'h00, 16'h0000);
    repeat (300) @(negedge clk);
    chk("R11 transfer finished then stop", 32'(xfer_k - k0), 32'd8);
    for (int j = 0; j < 8; j++) begin
      chk("R5 wrap order", {16'd0, cap_log[k0 + j]}, {16'd0, txw(2 + (j % 3))});
    end
    chk("R11 cs idle", {28'd0, spi_cs}, 32'hF);
    rd(6'h02, d);
    chk("R11 index held", 32'(d[7:4]), 32'd3);
    chk("R5 flag per pass", {31'd0, d[0]}, 32'd1);

    summary();
    $finish;
  end

endmodule